// File: doc/BRIEF.md
# Message to Packet Segmenter

This block sits between a processing element and the local port of an on-chip router. On the send side it accepts one outgoing message at a time. A message is described by a destination node and a length in 16-bit words, and the words themselves arrive on a separate valid/ready stream. The block cuts the message into packets whose total size never exceeds a configurable flit budget, 48 by default. Each packet opens with two header flits: the destination, then the number of payload words in that packet. The payload words follow, and all flits go to the router through a valid/ready handshake.

On the receive side the same block watches the flits leaving the router toward its element. Software or a controller arms it with the number of words it expects. It strips the header flits, presents payload words on a word output, counts them, and raises a one-cycle completion pulse only when the whole message has arrived. It does no routing and does not alter payload data.

Top module: `msg_segmenter`

## Requirements
- R1: While reset is held and right after its release, `msg_ready` is 1, `tx_valid` is 0 and `rx_done` is 0.
- R2: Every outgoing packet has this layout. The first flit is the destination, zero-extended to 16 bits. The second flit is the payload count of that packet, which lies in 1..46. The payload flits follow. A packet is therefore at most 48 flits long.
- R3: A message of L words becomes ceil(L/46) packets. Every packet except the final one carries 46 words. The final packet carries L minus 46 times the number of earlier packets, and its size flit shows that count.
- R4: Payload flits carry the words in the order they were accepted on the word stream, with their values unchanged.
- R5: `tx_last` is 1 on the final payload flit of each packet and 0 on every other flit.
- R6: A header flit stays valid with unchanged data while `tx_ready` is 0. During payload, `wr_ready` equals `tx_ready`. Outside payload, `wr_ready` is 0.
- R7: `msg_ready` falls after a message of non-zero length is accepted and stays 0 until the handshake of that message's last payload flit. A request made while busy is ignored, and the active destination is kept.
- R8: A message of length 0 is accepted and produces no flits. When the block is idle, `tx_valid` is 0.
- R9: The receiver is armed by a one-cycle `rx_arm` with `rx_len`. It counts the payload flits of incoming packets, where the second flit of each packet gives that packet's payload count. `rx_done` is 1 for exactly the one cycle that follows the flit completing the count.
- R10: Payload flits that arrive while the receiver is not armed never raise `rx_done`. Arming with length 0 raises `rx_done` in the cycle after the arm.
- R11: `rx_word_valid` is 1 only for incoming payload flits, never for header flits, and `rx_word_data` then carries the flit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| msg_valid | input | 1 | A message request is present |
| msg_ready | output | 1 | Idle, so a request is accepted |
| msg_dest | input | 8 | Destination node of the message |
| msg_len | input | 16 | Message length in words |
| wr_valid | input | 1 | A message word is present |
| wr_ready | output | 1 | The word is taken this cycle |
| wr_data | input | 16 | Message word |
| tx_valid | output | 1 | A flit is offered to the router |
| tx_ready | input | 1 | The router takes the flit |
| tx_data | output | 16 | Outgoing flit |
| tx_last | output | 1 | Final flit of the packet |
| rx_valid | input | 1 | An incoming flit is present |
| rx_data | input | 16 | Incoming flit |
| rx_arm | input | 1 | Start counting a new expected message |
| rx_len | input | 16 | Expected message length in words |
| rx_word_valid | output | 1 | An incoming payload word is present |
| rx_word_data | output | 16 | Incoming payload word |
| rx_done | output | 1 | One-cycle pulse when the full message has arrived |

## Verification
Flit contents and `tx_last` are combinational from the state. They are checked in the same cycle as each handshake, sampled on the falling edge before the handshake edge. `msg_ready` reacts one cycle after acceptance or after the last payload handshake, and the bench compares it every cycle against its own busy model. `rx_done` is due exactly one cycle after the completing flit, or one cycle after an arm with length 0. The bench records that expectation at the edge where the cause is visible and compares it at the next falling edge, so a late, early or stretched pulse is caught.

// File: rtl/msgseg_pkg.sv
package msgseg_pkg;

  typedef enum logic [1:0] {
    TX_IDLE,
    TX_DEST,
    TX_SIZE,
    TX_PAY
  } tx_state_e;

  typedef enum logic [1:0] {
    RX_HDR,
    RX_SIZE,
    RX_PAY
  } rx_state_e;

  // payload words that go into the next packet, given the words still owed
  function automatic int unsigned seg_chunk(input int unsigned rem, input int unsigned cap);
    return (rem > cap) ? cap : rem;
  endfunction

  // payload capacity of one packet once the header flits are taken out
  function automatic int unsigned seg_pay_cap(input int unsigned pkt_flits,
                                              input int unsigned hdr_flits);
    return pkt_flits - hdr_flits;
  endfunction

endpackage

// File: rtl/msgseg_tx.sv
module msgseg_tx
  import msgseg_pkg::*;
#(
  parameter int unsigned NODE_W  = 8,
  parameter int unsigned LEN_W   = 16,
  parameter int unsigned FLIT_W  = 16,
  parameter int unsigned PAY_MAX = 46
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              msg_valid,
  output logic              msg_ready,
  input  logic [NODE_W-1:0] msg_dest,
  input  logic [LEN_W-1:0]  msg_len,
  input  logic              wr_valid,
  output logic              wr_ready,
  input  logic [FLIT_W-1:0] wr_data,
  output logic              tx_valid,
  input  logic              tx_ready,
  output logic [FLIT_W-1:0] tx_data,
  output logic              tx_last,
  output logic              hdr_phase,
  output logic              size_phase,
  output logic              busy
);

  tx_state_e         state_q;
  logic [NODE_W-1:0] dest_q;
  logic [LEN_W-1:0]  rem_q;
  logic [LEN_W-1:0]  pk_q;
  logic [LEN_W-1:0]  chunk;
  logic [FLIT_W-1:0] dest_flit;
  logic [FLIT_W-1:0] size_flit;
  logic              fire;
  logic              pkt_end;
  logic              msg_end;

  assign chunk = LEN_W'(seg_chunk(32'(rem_q), PAY_MAX));

  generate
    if (NODE_W >= FLIT_W) begin : g_dest_trunc
      assign dest_flit = dest_q[FLIT_W-1:0];
    end else begin : g_dest_ext
      assign dest_flit = {{(FLIT_W-NODE_W){1'b0}}, dest_q};
    end
    if (LEN_W >= FLIT_W) begin : g_size_trunc
      assign size_flit = chunk[FLIT_W-1:0];
    end else begin : g_size_ext
      assign size_flit = {{(FLIT_W-LEN_W){1'b0}}, chunk};
    end
  endgenerate

  assign msg_ready  = (state_q == TX_IDLE);
  assign busy       = (state_q != TX_IDLE);
  assign hdr_phase  = (state_q == TX_DEST);
  assign size_phase = (state_q == TX_SIZE);
  assign fire       = tx_valid && tx_ready;
  assign pkt_end    = (pk_q == LEN_W'(1));
  assign msg_end    = (rem_q == LEN_W'(1));

  always_comb begin
    tx_valid = 1'b0;
    tx_data  = '0;
    tx_last  = 1'b0;
    wr_ready = 1'b0;
    case (state_q)
      TX_DEST: begin
        tx_valid = 1'b1;
        tx_data  = dest_flit;
      end
      TX_SIZE: begin
        tx_valid = 1'b1;
        tx_data  = size_flit;
      end
      TX_PAY: begin
        tx_valid = wr_valid;
        tx_data  = wr_data;
        wr_ready = tx_ready;
        tx_last  = wr_valid && pkt_end;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= TX_IDLE;
      dest_q  <= '0;
      rem_q   <= '0;
      pk_q    <= '0;
    end else begin
      case (state_q)
        TX_IDLE: begin
          if (msg_valid && (msg_len != '0)) begin
            dest_q  <= msg_dest;
            rem_q   <= msg_len;
            state_q <= TX_DEST;
          end
        end
        TX_DEST: begin
          if (fire) state_q <= TX_SIZE;
        end
        TX_SIZE: begin
          if (fire) begin
            pk_q    <= chunk;
            state_q <= TX_PAY;
          end
        end
        TX_PAY: begin
          if (fire) begin
            rem_q <= rem_q - LEN_W'(1);
            pk_q  <= pk_q - LEN_W'(1);
            if (pkt_end) state_q <= msg_end ? TX_IDLE : TX_DEST;
          end
        end
        default: state_q <= TX_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/msgseg_rx.sv
module msgseg_rx
  import msgseg_pkg::*;
#(
  parameter int unsigned LEN_W  = 16,
  parameter int unsigned FLIT_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_valid,
  input  logic [FLIT_W-1:0] rx_data,
  input  logic              rx_arm,
  input  logic [LEN_W-1:0]  rx_len,
  output logic              rx_word_valid,
  output logic [FLIT_W-1:0] rx_word_data,
  output logic              rx_done,
  output logic              count_hit
);

  rx_state_e        st_q;
  logic [LEN_W-1:0] pk_q;
  logic [LEN_W-1:0] exp_q;
  logic [LEN_W-1:0] got_q;
  logic             armed_q;
  logic             done_q;
  logic [LEN_W-1:0] size_in;
  logic             pay;

  generate
    if (FLIT_W >= LEN_W) begin : g_sz_trunc
      assign size_in = rx_data[LEN_W-1:0];
    end else begin : g_sz_ext
      assign size_in = {{(LEN_W-FLIT_W){1'b0}}, rx_data};
    end
  endgenerate

  assign pay           = rx_valid && (st_q == RX_PAY);
  assign rx_word_valid = pay;
  assign rx_word_data  = rx_data;
  assign count_hit     = pay && armed_q && ((got_q + LEN_W'(1)) == exp_q);
  assign rx_done       = done_q;

  // packet framing
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q <= RX_HDR;
      pk_q <= '0;
    end else if (rx_valid) begin
      case (st_q)
        RX_HDR:  st_q <= RX_SIZE;
        RX_SIZE: begin
          pk_q <= size_in;
          st_q <= (size_in == '0) ? RX_HDR : RX_PAY;
        end
        RX_PAY: begin
          pk_q <= pk_q - LEN_W'(1);
          if (pk_q == LEN_W'(1)) st_q <= RX_HDR;
        end
        default: st_q <= RX_HDR;
      endcase
    end
  end

  // message completion counting
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      exp_q   <= '0;
      got_q   <= '0;
      armed_q <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (rx_arm) begin
        exp_q   <= rx_len;
        got_q   <= '0;
        armed_q <= (rx_len != '0);
        done_q  <= (rx_len == '0);
      end else if (pay && armed_q) begin
        got_q <= got_q + LEN_W'(1);
        if (count_hit) begin
          armed_q <= 1'b0;
          done_q  <= 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/msg_segmenter.sv
module msg_segmenter
  import msgseg_pkg::*;
#(
  parameter int unsigned NODE_W    = 8,
  parameter int unsigned LEN_W     = 16,
  parameter int unsigned FLIT_W    = 16,
  parameter int unsigned PKT_FLITS = 48
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              msg_valid,
  output logic              msg_ready,
  input  logic [NODE_W-1:0] msg_dest,
  input  logic [LEN_W-1:0]  msg_len,
  input  logic              wr_valid,
  output logic              wr_ready,
  input  logic [FLIT_W-1:0] wr_data,
  output logic              tx_valid,
  input  logic              tx_ready,
  output logic [FLIT_W-1:0] tx_data,
  output logic              tx_last,
  input  logic              rx_valid,
  input  logic [FLIT_W-1:0] rx_data,
  input  logic              rx_arm,
  input  logic [LEN_W-1:0]  rx_len,
  output logic              rx_word_valid,
  output logic [FLIT_W-1:0] rx_word_data,
  output logic              rx_done
);

  localparam int unsigned HDR_FLITS = 2;
  localparam int unsigned PAY_MAX   = seg_pay_cap(PKT_FLITS, HDR_FLITS);

  // internal events brought out for the checker
  logic hdr_phase;
  logic size_phase;
  logic tx_busy;
  logic count_hit;

  msgseg_tx #(
    .NODE_W (NODE_W),
    .LEN_W  (LEN_W),
    .FLIT_W (FLIT_W),
    .PAY_MAX(PAY_MAX)
  ) tx_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .msg_valid (msg_valid),
    .msg_ready (msg_ready),
    .msg_dest  (msg_dest),
    .msg_len   (msg_len),
    .wr_valid  (wr_valid),
    .wr_ready  (wr_ready),
    .wr_data   (wr_data),
    .tx_valid  (tx_valid),
    .tx_ready  (tx_ready),
    .tx_data   (tx_data),
    .tx_last   (tx_last),
    .hdr_phase (hdr_phase),
    .size_phase(size_phase),
    .busy      (tx_busy)
  );

  msgseg_rx #(
    .LEN_W (LEN_W),
    .FLIT_W(FLIT_W)
  ) rx_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .rx_valid     (rx_valid),
    .rx_data      (rx_data),
    .rx_arm       (rx_arm),
    .rx_len       (rx_len),
    .rx_word_valid(rx_word_valid),
    .rx_word_data (rx_word_data),
    .rx_done      (rx_done),
    .count_hit    (count_hit)
  );

endmodule

// File: rtl/msgseg_chk.sv
module msgseg_chk #(
  parameter int unsigned LEN_W   = 16,
  parameter int unsigned FLIT_W  = 16,
  parameter int unsigned PAY_MAX = 46
) (
  input logic              clk,
  input logic              rst_n,
  input logic              msg_valid,
  input logic              msg_ready,
  input logic [LEN_W-1:0]  msg_len,
  input logic              wr_ready,
  input logic              tx_valid,
  input logic              tx_ready,
  input logic [FLIT_W-1:0] tx_data,
  input logic              tx_last,
  input logic              hdr_phase,
  input logic              size_phase,
  input logic              tx_busy,
  input logic              rx_arm,
  input logic [LEN_W-1:0]  rx_len,
  input logic              rx_done,
  input logic              count_hit
);

  assert_hdr_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready && (hdr_phase || size_phase)) |=> (tx_valid && $stable(tx_data)));

  assert_size_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (size_phase && tx_valid) |-> ((tx_data != '0) && (tx_data <= FLIT_W'(PAY_MAX))));

  assert_busy_after_accept_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (msg_valid && msg_ready && (msg_len != '0)) |=> !msg_ready);

  assert_last_on_payload_R5: assert property (@(posedge clk) disable iff (!rst_n)
    tx_last |-> (tx_valid && !hdr_phase && !size_phase));

  assert_word_gate_R6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ready |-> (tx_busy && !hdr_phase && !size_phase));

  assert_idle_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_busy |-> !tx_valid);

  assert_done_follows_hit_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (count_hit && !rx_arm) |=> rx_done);

  assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rx_done |=> (!rx_done || $past(rx_arm && (rx_len == '0))));

endmodule

bind msg_segmenter msgseg_chk #(
  .LEN_W  (LEN_W),
  .FLIT_W (FLIT_W),
  .PAY_MAX(PAY_MAX)
) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .msg_valid (msg_valid),
  .msg_ready (msg_ready),
  .msg_len   (msg_len),
  .wr_ready  (wr_ready),
  .tx_valid  (tx_valid),
  .tx_ready  (tx_ready),
  .tx_data   (tx_data),
  .tx_last   (tx_last),
  .hdr_phase (hdr_phase),
  .size_phase(size_phase),
  .tx_busy   (tx_busy),
  .rx_arm    (rx_arm),
  .rx_len    (rx_len),
  .rx_done   (rx_done),
  .count_hit (count_hit)
);

// File: tb/msg_segmenter_tb_top.sv
module msg_segmenter_tb_top;

  localparam int PAY = 46;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        msg_valid = 1'b0;
  logic        msg_ready;
  logic [7:0]  msg_dest = '0;
  logic [15:0] msg_len = '0;
  logic        wr_valid;
  logic        wr_ready;
  logic [15:0] wr_data;
  logic        tx_valid;
  logic        tx_ready;
  logic [15:0] tx_data;
  logic        tx_last;
  logic        rx_valid;
  logic [15:0] rx_data;
  logic        rx_arm = 1'b0;
  logic [15:0] rx_len = '0;
  logic        rx_word_valid;
  logic [15:0] rx_word_data;
  logic        rx_done;

  always #4 clk = ~clk;

  // the router is modelled as a loopback: every accepted flit comes straight back
  assign rx_valid = tx_valid && tx_ready;
  assign rx_data  = tx_data;

  msg_segmenter dut_i (
    .clk(clk), .rst_n(rst_n),
    .msg_valid(msg_valid), .msg_ready(msg_ready), .msg_dest(msg_dest), .msg_len(msg_len),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_data(wr_data),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data), .tx_last(tx_last),
    .rx_valid(rx_valid), .rx_data(rx_data), .rx_arm(rx_arm), .rx_len(rx_len),
    .rx_word_valid(rx_word_valid), .rx_word_data(rx_word_data), .rx_done(rx_done)
  );

  int checks = 0;
  int fails = 0;
  int cyc = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int exp_chunk(input int rem);
    return (rem > PAY) ? PAY : rem;
  endfunction

  function automatic logic [15:0] word_of(input int seed, input int idx);
    return 16'((seed * 7919 + idx * 37 + 5) & 32'hFFFF);
  endfunction

  // stimulus state
  int cur_seed = 0;
  int src_len = 0;
  int src_idx = 0;
  bit ready_always = 1'b1;
  bit mon_on = 1'b0;

  // reference model state
  int m_rem = 0, m_pk = 0, m_pos = 0, m_widx = 0, cur_dest = 0;
  bit m_armed = 1'b0;
  int m_got = 0, m_exp = 0;
  bit exp_done = 1'b0;
  bit hold_pend = 1'b0;
  logic [15:0] hold_val = '0;

  // word source and router backpressure, changed 2 ns after the rising edge
  always @(posedge clk) begin
    #2;
    wr_valid = (src_idx < src_len) && (($urandom % 4) != 0);
    wr_data  = word_of(cur_seed, src_idx);
    tx_ready = ready_always || (($urandom % 4) != 0);
  end

  // monitor on the falling edge: everything is settled for the next rising edge
  always @(negedge clk) begin
    if (mon_on) begin
      bit txf;
      bit done_n;
      txf = tx_valid && tx_ready;
      done_n = 1'b0;
      chk(rx_done == exp_done, "R9 rx_done timing", int'(rx_done), int'(exp_done));
      chk(msg_ready == (m_rem == 0), "R7 msg_ready busy", int'(msg_ready), int'(m_rem == 0));
      chk(wr_ready == (m_rem > 0 && m_pos == 2 && tx_ready), "R6 wr_ready gating",
          int'(wr_ready), int'(m_rem > 0 && m_pos == 2 && tx_ready));
      chk(rx_word_valid == (txf && m_pos == 2), "R11 rx_word_valid", int'(rx_word_valid),
          int'(txf && m_pos == 2));
      if (m_rem == 0) chk(!tx_valid, "R8 idle no flit", int'(tx_valid), 0);
      if (hold_pend) begin
        chk(tx_valid && tx_data == hold_val, "R6 header hold", int'(tx_data), int'(hold_val));
        hold_pend = 1'b0;
      end
      if (tx_valid && !tx_ready && m_rem > 0 && m_pos < 2) begin
        hold_pend = 1'b1;
        hold_val  = tx_data;
      end
      if (txf && m_rem > 0) begin
        case (m_pos)
          0: begin
            chk(tx_data == 16'(cur_dest), "R2 dest flit", int'(tx_data), cur_dest);
            chk(!tx_last, "R5 last on header", int'(tx_last), 0);
            m_pos = 1;
          end
          1: begin
            chk(int'(tx_data) == exp_chunk(m_rem), "R3 size flit", int'(tx_data), exp_chunk(m_rem));
            chk(!tx_last, "R5 last on size", int'(tx_last), 0);
            m_pk = exp_chunk(m_rem);
            m_pos = 2;
          end
          default: begin
            chk(tx_data == word_of(cur_seed, m_widx), "R4 payload word", int'(tx_data),
                int'(word_of(cur_seed, m_widx)));
            chk(rx_word_data == word_of(cur_seed, m_widx), "R11 rx word data", int'(rx_word_data),
                int'(word_of(cur_seed, m_widx)));
            chk(tx_last == (m_pk == 1), "R5 last flag", int'(tx_last), int'(m_pk == 1));
            m_widx++;
            m_rem--;
            m_pk--;
            src_idx++;
            if (m_armed) begin
              m_got++;
              if (m_got == m_exp) begin
                done_n = 1'b1;
                m_armed = 1'b0;
              end
            end
            if (m_pk == 0) m_pos = 0;
          end
        endcase
      end else if (txf) begin
        chk(1'b0, "R8 flit while idle", int'(tx_data), 0);
      end
      if (rx_arm) begin
        m_armed = (rx_len != 0);
        m_got = 0;
        m_exp = int'(rx_len);
        if (rx_len == 0) done_n = 1'b1;
      end
      if (msg_valid && msg_ready && msg_len != 0) begin
        m_rem = int'(msg_len);
        cur_dest = int'(msg_dest);
        m_pos = 0;
        m_widx = 0;
      end
      exp_done = done_n;
    end
  end

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      fails++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 150000);
      finish_run();
    end
  end

  task automatic run_msg(input int dest, input int len, input bit arm, input int seed);
    @(posedge clk); #2;
    if (arm) begin
      rx_arm = 1'b1;
      rx_len = 16'(len);
    end
    cur_seed = seed;
    src_len  = len;
    src_idx  = 0;
    @(posedge clk); #2;
    rx_arm    = 1'b0;
    msg_valid = 1'b1;
    msg_dest  = 8'(dest);
    msg_len   = 16'(len);
    do @(negedge clk); while (!msg_ready);
    @(posedge clk); #2;
    if (len > PAY) begin
      // R7: a second request during a busy message must be ignored
      msg_dest = 8'hEE;
      msg_len  = 16'd5;
      repeat (3) @(posedge clk);
      #2;
    end
    msg_valid = 1'b0;
    do @(negedge clk); while (m_rem != 0);
    repeat (3) @(negedge clk);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (4) @(posedge clk);
    @(negedge clk);
    chk(msg_ready == 1'b1, "R1 reset msg_ready", int'(msg_ready), 1);
    chk(tx_valid == 1'b0, "R1 reset tx_valid", int'(tx_valid), 0);
    chk(rx_done == 1'b0, "R1 reset rx_done", int'(rx_done), 0);
    @(posedge clk); #2;
    rst_n = 1'b1;
    @(negedge clk);
    chk(msg_ready == 1'b1 && tx_valid == 1'b0 && rx_done == 1'b0, "R1 after release",
        int'({msg_ready, tx_valid, rx_done}), 4);
    mon_on = 1'b1;

    // directed corners, router always ready
    ready_always = 1'b1;
    run_msg(3, 1, 1'b1, 11);     // R3 single word
    run_msg(7, 46, 1'b1, 12);    // R3 exactly one full packet
    run_msg(250, 47, 1'b1, 13);  // R3 one word spills into a second packet
    // directed corners under backpressure
    ready_always = 1'b0;
    run_msg(9, 92, 1'b1, 14);    // R3 two full packets
    run_msg(1, 93, 1'b1, 15);    // R3 two full plus one word
    run_msg(5, 0, 1'b1, 16);     // R8 empty message, R10 arm with zero
    run_msg(2, 30, 1'b0, 17);    // R10 unarmed receiver stays quiet
    run_msg(44, 200, 1'b1, 18);  // R2 many packets

    for (int i = 0; i < 12; i++) begin
      run_msg(int'($urandom % 256), 1 + int'($urandom % 150), ($urandom % 5) != 0, 100 + i);
    end

    finish_run();
  end

endmodule